// File: doc/BRIEF.md
# Serial Wiper Step Controller

This block owns the 8-bit wiper code of a digitally controlled potentiometer and moves it one tap at a time while the bus is in step mode. The command engine starts step mode once it has decoded the step instruction (opcode 0010 with all four bank and register selector bits zero) and has acknowledged the instruction byte. After that, every SCL high pulse is one step. The SDA level at the SCL rising edge gives the direction: high moves toward the high terminal and low moves toward the low terminal. The step takes effect when SCL falls. Any number of steps in either direction may follow in one command. A stop condition ends the mode, and so does a start condition.

The block takes single-cycle event pulses that have already been synchronised: SCL rise, SCL fall, start and stop. It also takes the SDA level and a parallel load port, which the command engine uses for direct wiper writes and register transfers. It drives the wiper code and a one-hot tap select vector. The wiper is volatile, so stepping never starts a nonvolatile write.

The controller has three states. IDLE means step mode is off. ARMED means the mode is on and SCL is low. HIGH means SCL is high and the direction has been latched. The transitions are: IDLE to ARMED on `mode_go`; ARMED to HIGH on `scl_rise`; HIGH to ARMED on `scl_fall`, which commits the step; and ARMED or HIGH to IDLE on `start_det` or `stop_det`, with no step taken.

Top module: `wiper_stepper`

## Requirements
- R1: After reset the wiper code equals the parameter RESET_CODE (default 8'h80) and `incdec_active` is low.
- R2: A `mode_go` pulse in IDLE raises `incdec_active` from the next clock edge on.
- R3: In step mode, a `scl_rise` pulse with `sda_in`=1 followed by a `scl_fall` pulse increases the wiper by exactly one. The new code is visible after the clock edge that samples `scl_fall`.
- R4: The same pulse pair with `sda_in`=0 at `scl_rise` decreases the wiper by exactly one.
- R5: At code 8'hFF an increment step leaves the code at 8'hFF; it never wraps to 8'h00.
- R6: At code 8'h00 a decrement step leaves the code at 8'h00; it never wraps to 8'hFF.
- R7: A `stop_det` pulse during step mode drops `incdec_active` and the pending pulse takes no step. Later SCL pulses have no effect.
- R8: A `start_det` pulse during step mode drops `incdec_active` and the pending pulse takes no step.
- R9: While `incdec_active` is low, SCL pulses leave the wiper unchanged.
- R10: `tap_sel` has exactly one bit set, and its index equals the wiper code. Bit 0 is the low terminal and bit 255 is the high terminal.
- R11: `ld_en` writes `ld_code` into the wiper on the next edge. It has priority over a step committed in the same cycle.
- R12: The direction is the `sda_in` level at `scl_rise`. A change of `sda_in` while SCL is high does not change the step direction.
- R13: Increments and decrements may be mixed without limit within one step-mode session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_go | input | 1 | Pulse from the command engine: enter step mode |
| scl_rise | input | 1 | Synchronised SCL rising-edge pulse |
| scl_fall | input | 1 | Synchronised SCL falling-edge pulse |
| sda_in | input | 1 | Synchronised SDA level |
| start_det | input | 1 | Start condition pulse |
| stop_det | input | 1 | Stop condition pulse |
| ld_en | input | 1 | Parallel load strobe |
| ld_code | input | 8 | Parallel load value |
| wiper_code | output | 8 | Current wiper position |
| tap_sel | output | 256 | One-hot tap switch enables |
| incdec_active | output | 1 | Step mode is on |

## Verification
The bench walks the wiper from 00h up past FFh and back down past 00h in single steps. At every position it checks the code and the one-hot tap vector. A counter that wraps fails at the ends, and a faulty decoder shows a wrong or duplicated bit. The bench ends the mode with a stop and with a start in the middle of an SCL high pulse. A design that commits steps at the SCL rise, or that ignores the exit events, would take an extra decrement or increment there. It also flips SDA during the high phase, pulses SCL outside the mode, and collides a load with a step, to catch a direction latched at the wrong time, steps taken while idle, and a wrong priority.

// File: rtl/wiper_stepper_pkg.sv
package wiper_stepper_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIGH  = 2'd2
    } incdec_state_e;
endpackage

// File: rtl/stepper_fsm.sv
module stepper_fsm
    import wiper_stepper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_go,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_in,
    input  logic start_det,
    input  logic stop_det,
    output logic step_req,
    output logic step_up,
    output logic active
);
    incdec_state_e state_q, state_d;
    logic dir_q, dir_d;
    logic bus_exit;

    assign bus_exit = start_det | stop_det;

    // next-state logic
    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_go) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (bus_exit) begin
                    state_d = ST_IDLE;
                end else if (scl_rise) begin
                    state_d = ST_HIGH;
                    dir_d   = sda_in;   // direction latched at SCL rise
                end
            end
            ST_HIGH: begin
                if (bus_exit)      state_d = ST_IDLE;
                else if (scl_fall) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    // outputs
    always_comb begin
        step_req = (state_q == ST_HIGH) && scl_fall && !bus_exit;
        step_up  = dir_q;
        active   = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
    parameter int          CODE_W     = 8,
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CODE_W-1:0] ld_code,
    input  logic              step_req,
    input  logic              step_up,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] ONE      = {{(CODE_W-1){1'b0}}, 1'b1};

    logic [CODE_W-1:0] code_q, code_d;

    always_comb begin
        code_d = code_q;
        if (ld_en) begin
            code_d = ld_code;
        end else if (step_req) begin
            if (step_up) begin
                if (code_q != CODE_MAX) code_d = code_q + ONE;
            end else begin
                if (code_q != CODE_MIN) code_d = code_q - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= RESET_CODE;
        else        code_q <= code_d;
    end

    assign code = code_q;
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int CODE_W = 8,
    localparam int TAPS  = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [TAPS-1:0]   sel
);
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign sel[i] = (code == CODE_W'(i));
    end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
    parameter int          CODE_W     = 8,
    parameter logic [CODE_W-1:0] RESET_CODE = 8'h80,
    localparam int         TAPS       = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_go,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ld_en,
    input  logic [CODE_W-1:0] ld_code,
    output logic [CODE_W-1:0] wiper_code,
    output logic [TAPS-1:0]   tap_sel,
    output logic              incdec_active
);
    logic step_req;
    logic step_up;

    stepper_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_go   (mode_go),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .step_req  (step_req),
        .step_up   (step_up),
        .active    (incdec_active)
    );

    wiper_counter #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_code  (ld_code),
        .step_req (step_req),
        .step_up  (step_up),
        .code     (wiper_code)
    );

    tap_decoder #(
        .CODE_W (CODE_W)
    ) u_dec (
        .code (wiper_code),
        .sel  (tap_sel)
    );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
    parameter int CODE_W = 8,
    localparam int TAPS  = 1 << CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_go,
    input logic              start_det,
    input logic              stop_det,
    input logic              ld_en,
    input logic [CODE_W-1:0] wiper_code,
    input logic [TAPS-1:0]   tap_sel,
    input logic              incdec_active,
    input logic              step_req
);
    localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

    // R3, R4: a step moves the code by at most one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> (wiper_code == $past(wiper_code)) ||
                   (wiper_code == $past(wiper_code) + ONE) ||
                   (wiper_code == $past(wiper_code) - ONE));

    // R5
    a_r5_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_code == CMAX && !ld_en) |=> wiper_code != '0);

    // R6
    a_r6_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_code == '0 && !ld_en) |=> wiper_code != CMAX);

    // R7
    a_r7_stop_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !mode_go) |=> !incdec_active);

    // R8
    a_r8_start_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !ld_en) |=> $stable(wiper_code));

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!incdec_active && !ld_en) |=> $stable(wiper_code));

    // R9: steps only while the mode is on
    a_r9_step_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> incdec_active);

    // R10
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_sel) == 1) && tap_sel[wiper_code]);
endmodule

bind wiper_stepper wiper_stepper_chk #(.CODE_W(CODE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_go       (mode_go),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .ld_en         (ld_en),
    .wiper_code    (wiper_code),
    .tap_sel       (tap_sel),
    .incdec_active (incdec_active),
    .step_req      (step_req)
);

// File: tb/sim_wiper_stepper.sv
module sim_wiper_stepper;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_go = 0, scl_rise = 0, scl_fall = 0, sda_in = 1;
    logic start_det = 0, stop_det = 0, ld_en = 0;
    logic [7:0]   ld_code = 8'h00;
    logic [7:0]   wiper_code;
    logic [255:0] tap_sel;
    logic         incdec_active;

    int n_run = 0;
    int n_fail = 0;
    int exp_code;

    always #(CLK_P/2) clk = ~clk;

    wiper_stepper u0 (
        .clk(clk), .rst_n(rst_n), .mode_go(mode_go),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .start_det(start_det), .stop_det(stop_det),
        .ld_en(ld_en), .ld_code(ld_code),
        .wiper_code(wiper_code), .tap_sel(tap_sel),
        .incdec_active(incdec_active)
    );

    task automatic chk(input string req, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_code(input string req);
        chk(req, int'(wiper_code), exp_code);
        chk({req, "/R10 tap"}, int'(tap_sel[exp_code[7:0]]) + 2 * $countones(tap_sel), 3);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic enter();
        mode_go = 1; tick(); mode_go = 0; tick();
    endtask

    task automatic rise(input logic d);
        sda_in = d; scl_rise = 1; tick(); scl_rise = 0; tick();
    endtask

    task automatic fall();
        scl_fall = 1; tick(); scl_fall = 0; tick();
    endtask

    task automatic step(input logic d);
        rise(d); fall();
        if (d && exp_code < 255) exp_code++;
        else if (!d && exp_code > 0) exp_code--;
    endtask

    task automatic load(input int v);
        ld_code = 8'(v); ld_en = 1; tick(); ld_en = 0; tick();
        exp_code = v;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_run++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        tick(); tick();
        rst_n = 1; tick();
        // R1 reset state
        exp_code = 8'h80;
        chk_code("R1");
        chk("R1 active", int'(incdec_active), 0);

        // R9: SCL pulses outside mode
        rise(1); fall(); rise(0); fall();
        chk_code("R9");

        // R2 enter
        load(0);
        enter();
        chk("R2 active", int'(incdec_active), 1);

        // R3 / R5 sweep up past the top
        for (int i = 0; i < 260; i++) begin
            step(1);
            chk_code("R3/R5");
        end
        chk("R5 top", int'(wiper_code), 255);

        // R4 / R6 sweep down past the bottom
        for (int i = 0; i < 260; i++) begin
            step(0);
            chk_code("R4/R6");
        end
        chk("R6 bottom", int'(wiper_code), 0);

        // R13 mixed pattern
        load(100);
        for (int i = 0; i < 64; i++) begin
            step(((i * 7) % 3) != 0);
            chk_code("R13");
        end
        chk("R13 active", int'(incdec_active), 1);

        // R12 SDA toggles during high phase
        rise(1); sda_in = 0; tick(); fall();
        exp_code++;
        chk_code("R12 up");
        rise(0); sda_in = 1; tick(); fall();
        exp_code--;
        chk_code("R12 down");

        // R11 load collides with a committed step
        rise(1);
        ld_code = 8'h33; ld_en = 1; scl_fall = 1; tick();
        ld_en = 0; scl_fall = 0; tick();
        exp_code = 8'h33;
        chk_code("R11");

        // R7 stop: SDA low at rise, stop while high, then fall
        rise(0);
        stop_det = 1; tick(); stop_det = 0; tick();
        fall();
        chk_code("R7 no step");
        chk("R7 active", int'(incdec_active), 0);
        rise(1); fall(); rise(0); fall();
        chk_code("R7 after");

        // R8 start inside mode
        enter();
        rise(1);
        start_det = 1; tick(); start_det = 0; tick();
        fall();
        chk_code("R8 no step");
        chk("R8 active", int'(incdec_active), 0);

        // R8/R9: start with no mode active changes nothing
        start_det = 1; tick(); start_det = 0; tick();
        rise(1); fall();
        chk_code("R9 idle");

        // R1 reset again
        rst_n = 0; tick(); rst_n = 1; tick();
        exp_code = 8'h80;
        chk_code("R1 again");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule